// File: doc/BRIEF.md
# Mode-banked register file

This block holds the sixteen general registers of a processor core together with the current operating mode. Some register numbers resolve to private storage that depends on the mode. A 5-bit mode code chooses among those mappings. The fast-interrupt mode has its own copies of registers 8 to 14. Each of the other four exception modes (interrupt, supervisor, abort, undefined) has its own copy of registers 13 and 14. Every other mode code uses the shared set. The mapping is done by address decode, so no data moves when the mode changes. The new mapping applies from the cycle after the mode is loaded.

Each exception mode also owns a saved-status word. The saved-status port reads and writes the word that belongs to the current mode. A restore request loads the mode from bits 4:0 of that word. In a mode that has no saved-status word, a restore request leaves the mode as it is and pulses an error flag instead. Computing status words and executing instructions are outside this block.

Top module: `banked_regfile`

## Requirements
- R1: After reset the mode is 0x13 (supervisor), every register reads zero through both read ports, the saved-status read is zero and `restore_err` is low.
- R2: Registers 0 to 7 and register 15 are one shared set, and every mode sees the same contents for them.
- R3: In mode 0x11, registers 8 to 14 resolve to seven private registers, used by that mode only.
- R4: In modes 0x12, 0x13, 0x17 and 0x1B, registers 13 and 14 resolve to a private pair for each of these modes, and registers 8 to 12 resolve to the shared set.
- R5: Any other mode code (for example 0x10 or 0x1F) uses only the shared registers.
- R6: When `mode_set` is high at a clock edge and there is no restore request, the mode takes `mode_in` after that edge. Reads are combinational and follow the registered mode. With neither request, the mode holds.
- R7: A write in the same cycle as a mode change goes to the register that the old mode selects.
- R8: `sts_wr_en` writes the saved-status word of the current exception mode, and `sts_rd_data` returns it. In a mode without a saved-status word, the read returns zero and the write changes no stored word.
- R9: A restore request in an exception mode sets the mode to bits 4:0 of that mode's saved-status word after the edge. It takes priority over `mode_set`, and `restore_err` stays low.
- R10: A restore request in a mode without a saved-status word leaves the mode unchanged and raises `restore_err` for exactly the following cycle.
- R11: The two read ports are independent, and each can return a different register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_addr_a | input | 4 | Register number for read port A |
| rd_data_a | output | DW | Read data for port A |
| rd_addr_b | input | 4 | Register number for read port B |
| rd_data_b | output | DW | Read data for port B |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 4 | Register number to write |
| wr_data | input | DW | Write data |
| mode_set | input | 1 | Load `mode_in` as the new mode |
| mode_in | input | 5 | New mode code |
| mode_out | output | 5 | Current mode code |
| sts_wr_en | input | 1 | Write the current mode's saved-status word |
| sts_wr_data | input | DW | Saved-status write data |
| sts_rd_data | output | DW | Current mode's saved-status word |
| restore_req | input | 1 | Load the mode from the saved-status word |
| restore_err | output | 1 | Restore was attempted in a mode without a saved-status word |

## Verification
The bench visits seven mode codes in turn: two unbanked, the fast-interrupt mode and the four pair-banked modes. In each mode it writes every register with a value that encodes both the mode and the register number. It then revisits every mode and reads all sixteen registers on both ports. Each read value shows which mode last wrote that physical slot, so the check can tell a shared slot from a private one. It also shows whether registers 8 to 12 were banked wrongly for the pair-banked modes. Further directed patterns cover a write that coincides with a mode change, a restore that coincides with `mode_set`, and the saved-status accesses in a mode that has no saved-status word.

// File: rtl/banked_regfile.sv
module banked_regfile #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    rd_addr_a,
  output logic [DW-1:0] rd_data_a,
  input  logic [3:0]    rd_addr_b,
  output logic [DW-1:0] rd_data_b,
  input  logic          wr_en,
  input  logic [3:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          mode_set,
  input  logic [4:0]    mode_in,
  output logic [4:0]    mode_out,
  input  logic          sts_wr_en,
  input  logic [DW-1:0] sts_wr_data,
  output logic [DW-1:0] sts_rd_data,
  input  logic          restore_req,
  output logic          restore_err
);
  localparam int NREG = 16;
  localparam int NFIQ = 7;
  localparam int NPAIR = 4;
  localparam int NSTS = NPAIR + 1;

  localparam logic [4:0] M_FIQ = 5'h11;
  localparam logic [4:0] M_IRQ = 5'h12;
  localparam logic [4:0] M_SVC = 5'h13;
  localparam logic [4:0] M_ABT = 5'h17;
  localparam logic [4:0] M_UND = 5'h1B;

  localparam logic [2:0] B_NONE = 3'd0;
  localparam logic [2:0] B_FIQ  = 3'd1;
  localparam logic [2:0] B_IRQ  = 3'd2;
  localparam logic [2:0] B_SVC  = 3'd3;
  localparam logic [2:0] B_ABT  = 3'd4;
  localparam logic [2:0] B_UND  = 3'd5;

  logic [DW-1:0] comm  [NREG];
  logic [DW-1:0] fiqb  [NFIQ];
  logic [DW-1:0] pairb [NPAIR][2];
  logic [DW-1:0] spsr  [NSTS];
  logic [4:0]    mode_q;
  logic [2:0]    bank;

  function automatic logic [2:0] bank_of(input logic [4:0] m);
    case (m)
      M_FIQ:   return B_FIQ;
      M_IRQ:   return B_IRQ;
      M_SVC:   return B_SVC;
      M_ABT:   return B_ABT;
      M_UND:   return B_UND;
      default: return B_NONE;
    endcase
  endfunction

  assign bank = bank_of(mode_q);

  function automatic logic in_fiq(input logic [2:0] b, input logic [3:0] a);
    return b == B_FIQ && a >= 4'd8 && a <= 4'd14;
  endfunction

  function automatic logic in_pair(input logic [2:0] b, input logic [3:0] a);
    return b >= B_IRQ && (a == 4'd13 || a == 4'd14);
  endfunction

  function automatic logic [DW-1:0] pick(input logic [3:0] a);
    if (in_fiq(bank, a))       return fiqb[3'(a - 4'd8)];
    else if (in_pair(bank, a)) return pairb[2'(bank - B_IRQ)][~a[0]];
    else                       return comm[a];
  endfunction

  assign rd_data_a   = pick(rd_addr_a);
  assign rd_data_b   = pick(rd_addr_b);
  assign mode_out    = mode_q;
  assign sts_rd_data = (bank == B_NONE) ? '0 : spsr[3'(bank - 3'd1)];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) comm[i] <= '0;
      for (int i = 0; i < NFIQ; i++) fiqb[i] <= '0;
      for (int i = 0; i < NPAIR; i++) begin
        pairb[i][0] <= '0;
        pairb[i][1] <= '0;
      end
      for (int i = 0; i < NSTS; i++) spsr[i] <= '0;
      mode_q      <= M_SVC;
      restore_err <= 1'b0;
    end else begin
      if (wr_en) begin
        if (in_fiq(bank, wr_addr))       fiqb[3'(wr_addr - 4'd8)] <= wr_data;
        else if (in_pair(bank, wr_addr)) pairb[2'(bank - B_IRQ)][~wr_addr[0]] <= wr_data;
        else                             comm[wr_addr] <= wr_data;
      end
      if (sts_wr_en && bank != B_NONE) spsr[3'(bank - 3'd1)] <= sts_wr_data;
      restore_err <= restore_req && bank == B_NONE;
      if (restore_req) begin
        if (bank != B_NONE) mode_q <= spsr[3'(bank - 3'd1)][4:0];
      end else if (mode_set) begin
        mode_q <= mode_in;
      end
    end
  end

  p_mode_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !restore_req && !mode_set |=> $stable(mode_out));
  p_mode_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !restore_req && mode_set |=> mode_out == $past(mode_in));
  p_common_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (wr_addr < 4'd8 || wr_addr == 4'd15) |=> comm[$past(wr_addr)] == $past(wr_data));
  p_restore_ok_r9: assert property (@(posedge clk) disable iff (!rst_n)
    restore_req && bank != B_NONE |=> mode_out == $past(sts_rd_data[4:0]) && !restore_err);
  p_restore_bad_r10: assert property (@(posedge clk) disable iff (!rst_n)
    restore_req && bank == B_NONE |=> restore_err && $stable(mode_out));
  p_err_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    restore_err |-> $past(restore_req));
endmodule

// File: tb/test_banked_regfile.sv
module test_banked_regfile;
  localparam int CLK_P = 10;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] rd_addr_a = '0, rd_addr_b = '0, wr_addr = '0;
  logic [DW-1:0] rd_data_a, rd_data_b, wr_data = '0, sts_wr_data = '0, sts_rd_data;
  logic wr_en = 1'b0, mode_set = 1'b0, sts_wr_en = 1'b0, restore_req = 1'b0, restore_err;
  logic [4:0] mode_in = '0, mode_out;
  int n_chk = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  banked_regfile #(.DW(DW)) i_banked_regfile (
    .clk(clk), .rst_n(rst_n),
    .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
    .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .mode_set(mode_set), .mode_in(mode_in), .mode_out(mode_out),
    .sts_wr_en(sts_wr_en), .sts_wr_data(sts_wr_data), .sts_rd_data(sts_rd_data),
    .restore_req(restore_req), .restore_err(restore_err));

  logic [4:0] mlist [7] = '{5'h10, 5'h11, 5'h12, 5'h13, 5'h17, 5'h1B, 5'h1F};

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic set_mode(input logic [4:0] m);
    mode_set = 1'b1; mode_in = m;
    tick();
    mode_set = 1'b0;
  endtask

  task automatic wr(input logic [3:0] r, input logic [DW-1:0] v);
    wr_en = 1'b1; wr_addr = r; wr_data = v;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic rd_a(input logic [3:0] r, output logic [DW-1:0] v);
    rd_addr_a = r;
    #1;
    v = rd_data_a;
  endtask

  function automatic int slot(input logic [4:0] m, input int r);
    int k;
    k = (m == 5'h12) ? 2 : (m == 5'h13) ? 3 : (m == 5'h17) ? 4 : (m == 5'h1B) ? 5 : 0;
    if (m == 5'h11 && r >= 8 && r <= 14) return 100 + r;
    if (k != 0 && (r == 13 || r == 14)) return 200 + k * 10 + r;
    return r;
  endfunction

  function automatic logic [DW-1:0] tagv(input logic [4:0] m, input int r);
    return {8'hA5, 3'b000, m, 12'h000, 4'(r)};
  endfunction

  function automatic logic [DW-1:0] expect_sweep(input logic [4:0] m, input int r);
    int last;
    last = 0;
    for (int j = 0; j < 7; j++)
      if (slot(mlist[j], r) == slot(m, r)) last = j;
    return tagv(mlist[last], r);
  endfunction

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [DW-1:0] v;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 mode", {27'd0, mode_out}, 32'h13);
    chk("R1 err", {31'd0, restore_err}, 32'd0);
    chk("R1 sts", sts_rd_data, 32'd0);
    for (int r = 0; r < 16; r++) begin
      rd_addr_a = 4'(r); rd_addr_b = 4'(15 - r);
      #1;
      chk("R1 reg a", rd_data_a, 32'd0);
      chk("R1 reg b", rd_data_b, 32'd0);
    end

    // R3 R4 R5 R2: write every register in every mode
    for (int i = 0; i < 7; i++) begin
      set_mode(mlist[i]);
      chk("R6 mode load", {27'd0, mode_out}, {27'd0, mlist[i]});
      for (int r = 0; r < 16; r++) wr(4'(r), tagv(mlist[i], r));
    end
    // R11: ports read different registers at once
    for (int i = 0; i < 7; i++) begin
      set_mode(mlist[i]);
      for (int r = 0; r < 16; r++) begin
        rd_addr_a = 4'(r); rd_addr_b = 4'(15 - r);
        #1;
        chk("R2-R5 sweep port a", rd_data_a, expect_sweep(mlist[i], r));
        chk("R11 sweep port b", rd_data_b, expect_sweep(mlist[i], 15 - r));
      end
    end

    // R6: reloading the same mode keeps the mapping
    set_mode(5'h11);
    set_mode(5'h11);
    rd_a(4'd10, v);
    chk("R6 same mode", v, tagv(5'h11, 10));

    // R7: write coincides with mode change
    set_mode(5'h10);
    mode_set = 1'b1; mode_in = 5'h12;
    wr_en = 1'b1; wr_addr = 4'd13; wr_data = 32'hC0DE_0013;
    tick();
    mode_set = 1'b0; wr_en = 1'b0;
    chk("R7 new mode", {27'd0, mode_out}, 32'h12);
    rd_a(4'd13, v);
    chk("R7 irq pair untouched", v, tagv(5'h12, 13));
    set_mode(5'h10);
    rd_a(4'd13, v);
    chk("R7 old mode got write", v, 32'hC0DE_0013);

    // R8: saved status words
    for (int i = 2; i < 6; i++) begin
      set_mode(mlist[i]);
      sts_wr_en = 1'b1;
      sts_wr_data = {16'h5A5A, 8'(i), 3'b000, (mlist[i] == 5'h13) ? 5'h12 : 5'h10};
      tick();
      sts_wr_en = 1'b0;
    end
    set_mode(5'h11);
    sts_wr_en = 1'b1; sts_wr_data = 32'h0000_7711;
    tick();
    sts_wr_en = 1'b0;
    for (int i = 2; i < 6; i++) begin
      set_mode(mlist[i]);
      chk("R8 sts readback", sts_rd_data,
          {16'h5A5A, 8'(i), 3'b000, (mlist[i] == 5'h13) ? 5'h12 : 5'h10});
    end
    set_mode(5'h11);
    chk("R8 fiq sts", sts_rd_data, 32'h0000_7711);
    set_mode(5'h1F);
    chk("R8 none reads zero", sts_rd_data, 32'd0);
    sts_wr_en = 1'b1; sts_wr_data = 32'hDEAD_BEEF;
    tick();
    sts_wr_en = 1'b0;
    chk("R8 none still zero", sts_rd_data, 32'd0);
    set_mode(5'h12);
    chk("R8 none write ignored", sts_rd_data, {16'h5A5A, 8'd2, 8'h10});

    // R9: restore wins over mode_set
    set_mode(5'h13);
    restore_req = 1'b1; mode_set = 1'b1; mode_in = 5'h1B;
    tick();
    restore_req = 1'b0; mode_set = 1'b0;
    chk("R9 restore mode", {27'd0, mode_out}, 32'h12);
    chk("R9 no err", {31'd0, restore_err}, 32'd0);
    restore_req = 1'b1;
    tick();
    restore_req = 1'b0;
    chk("R9 restore from irq", {27'd0, mode_out}, 32'h10);

    // R10: restore without saved status
    restore_req = 1'b1;
    tick();
    restore_req = 1'b0;
    chk("R10 err raised", {31'd0, restore_err}, 32'd1);
    chk("R10 mode kept", {27'd0, mode_out}, 32'h10);
    tick();
    chk("R10 err one cycle", {31'd0, restore_err}, 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule